// File: doc/BRIEF.md
# Partitionable Multiplier Array

This block is a two-stage multiplier whose 36-bit operand buses can be split into several narrow, independent products or used whole for one wide product. A two-bit mode input picks the split on every accepted beat. The four splits are four 9x9 products, three 12x12 products, two 18x18 products, or one 36x36 product. Two further inputs choose, one per operand, whether the bits are read as two's-complement or as unsigned. The same choice applies to every lane of that operand.

Lane k of an operand sits in the operand bus starting at bit k times the lane width, with lane 0 in the lowest bits. Lane k's product sits in the 72-bit result bus starting at bit k times twice the lane width. In every mode the lanes fill both buses exactly.

An input register stage captures the operands, and an output register stage holds the selected product. Every mode has the same latency. A valid flag travels through the same two stages, so the valid output lines up with the result. A new beat may be accepted on every clock, and the mode may change from one beat to the next.

Top module: `pmul_array`

## Requirements
- R1: While `rst` is high, the next rising edge clears `valid_o` to 0 and `result_o` to all zeros.
- R2: With mode 2'b00, lane k (k = 0..3) multiplies `a_i[9k+8:9k]` by `b_i[9k+8:9k]`, and the 18-bit product appears at `result_o[18k+17:18k]`.
- R3: With mode 2'b01, lane k (k = 0..2) multiplies `a_i[12k+11:12k]` by `b_i[12k+11:12k]`, and the 24-bit product appears at `result_o[24k+23:24k]`.
- R4: With mode 2'b10, lane k (k = 0..1) multiplies `a_i[18k+17:18k]` by `b_i[18k+17:18k]`, and the 36-bit product appears at `result_o[36k+35:36k]`.
- R5: With mode 2'b11, the whole of `a_i` is multiplied by the whole of `b_i`, and the 72-bit product appears on `result_o`.
- R6: When `a_signed_i` is 1, every lane of `a_i` is read as two's-complement; when it is 0, every lane of `a_i` is read as unsigned. `b_signed_i` does the same for `b_i`. Each product is the exact value, written as a two's-complement number in its field, and a zero operand always gives a zero product.
- R7: A beat accepted with `valid_i` high at one rising edge makes `valid_o` high and shows its product on `result_o` after the second rising edge. Beats may be back to back, and the mode and signedness may change on every beat.
- R8: While `valid_o` is low, `result_o` keeps its last value. Operand, mode and sign inputs presented with `valid_i` low have no effect on the result.
- R9: Lanes are independent: no carry, borrow or sign extension of one lane's product reaches a neighbouring lane's field, even at the extreme values of every lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | The current inputs form a beat to be multiplied |
| mode_i | input | 2 | Split select: 00 = 4x9, 01 = 3x12, 10 = 2x18, 11 = 1x36 |
| a_signed_i | input | 1 | 1 = lanes of a_i are two's-complement, 0 = unsigned |
| b_signed_i | input | 1 | 1 = lanes of b_i are two's-complement, 0 = unsigned |
| a_i | input | 36 | Packed first operand lanes |
| b_i | input | 36 | Packed second operand lanes |
| valid_o | output | 1 | result_o carries a new product this cycle |
| result_o | output | 72 | Packed lane products |

## Verification
The bench builds the block with the default operand width of 36. This gives the four lane widths 9, 12, 18 and 36 and a 72-bit result, so every split the mode input offers can be reached. At that width the bench drives the most negative value, all ones, and zero into every lane of every split, under all four signedness pairs. These values reach both ends of each product field, where a sign or carry leaking into a neighbouring lane would show. A stream of back-to-back beats with the mode chosen at random on every cycle, plus idle stretches that carry junk on the operand inputs, covers the latency and the hold behaviour.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD9  = 2'd0,
    MODE_TRI12  = 2'd1,
    MODE_DUO18  = 2'd2,
    MODE_MONO36 = 2'd3
  } pmul_mode_e;

  localparam int NUM_MODES = 4;

  // number of independent lanes a split produces
  function automatic int lanes_of(input int mode_idx);
    return NUM_MODES - mode_idx;
  endfunction

endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int W = 9
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           a_signed_i,
  input  logic           b_signed_i,
  output logic [2*W-1:0] prod_o
);

  // widen to the product width; the low 2W bits of the product are exact
  function automatic logic [2*W-1:0] widen(input logic [W-1:0] v, input logic s);
    return {{W{s & v[W-1]}}, v};
  endfunction

  logic [2*W-1:0] a_wide;
  logic [2*W-1:0] b_wide;

  assign a_wide = widen(a_i, a_signed_i);
  assign b_wide = widen(b_i, b_signed_i);
  assign prod_o = a_wide * b_wide;

endmodule

// File: rtl/pmul_group.sv
module pmul_group #(
  parameter  int LW = 9,
  parameter  int N  = 4,
  localparam int OW = LW * N
) (
  input  logic [OW-1:0]   a_i,
  input  logic [OW-1:0]   b_i,
  input  logic            a_signed_i,
  input  logic            b_signed_i,
  output logic [2*OW-1:0] prod_o
);

  for (genvar k = 0; k < N; k++) begin : g_lane
    pmul_lane #(.W(LW)) u_lane (
      .a_i        (a_i[k*LW +: LW]),
      .b_i        (b_i[k*LW +: LW]),
      .a_signed_i (a_signed_i),
      .b_signed_i (b_signed_i),
      .prod_o     (prod_o[k*2*LW +: 2*LW])
    );
  end

endmodule

// File: rtl/pmul_array.sv
module pmul_array #(
  parameter int OP_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic              valid_o,
  output logic [2*OP_W-1:0] result_o
);
  import pmul_pkg::*;

  localparam int RES_W = 2 * OP_W;

  // input stage
  logic              s1_valid;
  pmul_mode_e        s1_mode;
  logic              s1_a_signed;
  logic              s1_b_signed;
  logic [OP_W-1:0]   s1_a;
  logic [OP_W-1:0]   s1_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid    <= 1'b0;
      s1_mode     <= MODE_QUAD9;
      s1_a_signed <= 1'b0;
      s1_b_signed <= 1'b0;
      s1_a        <= '0;
      s1_b        <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_mode     <= pmul_mode_e'(mode_i);
        s1_a_signed <= a_signed_i;
        s1_b_signed <= b_signed_i;
        s1_a        <= a_i;
        s1_b        <= b_i;
      end
    end
  end

  // one lane group per split, each filling the whole result width
  logic [RES_W-1:0] split_prod [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_split
    localparam int NL = lanes_of(g);
    localparam int LW = OP_W / NL;
    logic [2*NL*LW-1:0] part;

    pmul_group #(.LW(LW), .N(NL)) u_grp (
      .a_i        (s1_a[NL*LW-1:0]),
      .b_i        (s1_b[NL*LW-1:0]),
      .a_signed_i (s1_a_signed),
      .b_signed_i (s1_b_signed),
      .prod_o     (part)
    );
    assign split_prod[g] = RES_W'(part);
  end

  logic [RES_W-1:0] sel_prod;
  assign sel_prod = split_prod[s1_mode];

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) result_o <= sel_prod;
    end
  end

endmodule

// File: rtl/pmul_array_chk.sv
module pmul_array_chk #(
  parameter int OP_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic              a_signed_i,
  input logic              b_signed_i,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic              valid_o,
  input logic [2*OP_W-1:0] result_o,
  input logic              s1_valid
);

  // cycles since reset release, saturating at 3
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic [2*OP_W-1:0] full_unsigned;
  assign full_unsigned = {{OP_W{1'b0}}, a_i} * {{OP_W{1'b0}}, b_i};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && result_o == '0));

  p_valid_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_stage_link_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1) |-> (valid_o == $past(s1_valid)));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !valid_o) |-> $stable(result_o));

  p_zero_operand_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(valid_i && a_i == '0, 2)) |-> (result_o == '0));

  p_full_unsigned_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 &&
     $past(valid_i && mode_i == 2'd3 && !a_signed_i && !b_signed_i, 2))
    |-> (result_o == $past(full_unsigned, 2)));

endmodule

bind pmul_array pmul_array_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/pmul_array_tb.sv
module pmul_array_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OPW = 36;
  localparam int RW  = 72;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          a_signed_i = 1'b0;
  logic          b_signed_i = 1'b0;
  logic [OPW-1:0] a_i = '0;
  logic [OPW-1:0] b_i = '0;
  logic          valid_o;
  logic [RW-1:0] result_o;

  int compared = 0;
  int mismatched = 0;
  bit live = 1'b0;

  logic [RW-1:0] exp_q [$];
  string         tag_q [$];
  logic [RW-1:0] held = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmul_array u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
    .a_signed_i(a_signed_i), .b_signed_i(b_signed_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  // reference: per-lane exact value via subtraction of 2^w for negatives
  function automatic logic [RW-1:0] model(input logic [1:0] m, input bit sa, input bit sb,
                                          input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    int n = 4 - int'(m);
    int w = OPW / n;
    logic [RW-1:0] r = '0;
    for (int k = 0; k < n; k++) begin
      logic signed [79:0] x, y, p;
      logic [79:0] msk, msk2;
      msk  = (80'd1 << w) - 80'd1;
      msk2 = (80'd1 << (2*w)) - 80'd1;
      x = $signed((80'(a) >> (k*w)) & msk);
      y = $signed((80'(b) >> (k*w)) & msk);
      if (sa && x[w-1]) x = x - $signed(80'd1 << w);
      if (sb && y[w-1]) y = y - $signed(80'd1 << w);
      p = x * y;
      r = r | (RW'(p & msk2) << (k*2*w));
    end
    return r;
  endfunction

  function automatic logic [OPW-1:0] fill(input logic [1:0] m, input logic [OPW-1:0] lane);
    int n = 4 - int'(m);
    int w = OPW / n;
    logic [OPW-1:0] r = '0;
    for (int k = 0; k < n; k++) r = r | ((lane & ((OPW'(1) << w) - 1)) << (k*w));
    if (n == 1) r = lane;
    return r;
  endfunction

  function automatic logic [OPW-1:0] min_lane(input logic [1:0] m);
    int w = OPW / (4 - int'(m));
    return fill(m, OPW'(1) << (w-1));
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic send(input logic [1:0] m, input bit sa, input bit sb,
                      input logic [OPW-1:0] a, input logic [OPW-1:0] b, input string tag);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; a_signed_i = sa; b_signed_i = sb; a_i = a; b_i = b;
    exp_q.push_back(model(m, sa, sb, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      mode_i = 2'($urandom); a_signed_i = 1'($urandom); b_signed_i = 1'($urandom);
      a_i = OPW'({$urandom, $urandom}); b_i = OPW'({$urandom, $urandom});
    end
  endtask

  // monitor: scoreboard compare on valid, hold check otherwise
  always @(negedge clk) begin
    if (live) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R7: valid_o high with nothing expected, got %h", result_o);
        end else begin
          logic [RW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          compared++;
          if (result_o !== e) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", t, result_o, e);
          end
        end
        held = result_o;
      end else begin
        compared++;
        if (result_o !== held) begin
          mismatched++;
          $display("FAIL R8: idle result got %h expected %h", result_o, held);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [1:0] sgn [4];
    sgn[0] = 2'b00; sgn[1] = 2'b11; sgn[2] = 2'b10; sgn[3] = 2'b01;

    // R1: reset state
    valid_i = 1'b1; a_i = '1; b_i = '1;
    repeat (3) @(negedge clk);
    compared++;
    if (valid_o !== 1'b0 || result_o !== '0) begin
      mismatched++;
      $display("FAIL R1: got valid %b result %h expected 0 / 0", valid_o, result_o);
    end
    valid_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    live = 1'b1;

    // R2..R6, R9: extremes in every lane of every split and sign pair
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [1:0] mm;
        mm = 2'(m);
        send(mm, sgn[s][1], sgn[s][0], '1, '1, req_of(mm));
        send(mm, sgn[s][1], sgn[s][0], min_lane(mm), min_lane(mm), "R9 min*min");
        send(mm, sgn[s][1], sgn[s][0], min_lane(mm), '1, "R9 min*ones");
        send(mm, sgn[s][1], sgn[s][0], '0, OPW'({$urandom, $urandom}), "R6 zero");
        send(mm, sgn[s][1], sgn[s][0], ~min_lane(mm), min_lane(mm), "R9 max*min");
        idle(2);
      end
    end

    // random beats per split and sign pair, with idle gaps (R8)
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 30; i++) begin
          send(2'(m), sgn[s][1], sgn[s][0], OPW'({$urandom, $urandom}),
               OPW'({$urandom, $urandom}), req_of(2'(m)));
          if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
        end
      end
    end

    // R7: back to back with mode and signs changing every beat
    for (int i = 0; i < 400; i++) begin
      send(2'($urandom), 1'($urandom), 1'($urandom), OPW'({$urandom, $urandom}),
           OPW'({$urandom, $urandom}), "R7 back-to-back");
    end

    idle(6);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R7: got %0d results outstanding expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule